// File: doc/BRIEF.md
# Power Button Hold Timer

This block turns a clean power button level into two kinds of one-cycle requests for a power sequencer: a power-on request and a forced-shutdown request. Delays are counted in pulses of a free-running millisecond tick. One press can start two deferred actions at once. A short boot delay is armed only if the chipset reports that it is off at the moment of the press. A long forced-off delay is armed on every press. Letting go of the button cancels whatever is still pending.

Two other events also raise requests. A lid that opens while the chipset is off asks for power-on at once. A suspend entry seen while the button is still held, with the forced-off action still pending, ends the wait and asks for shutdown at once. Debouncing and the power state machine sit outside this block.

Top module: `pbtn_hold_timer`

## Requirements
- R1: After reset both request outputs are low. A button that is already held when reset ends does not count as a press until it is released and pressed again.
- R2: A press while `chipOff` is high produces a one-cycle `powerOnReq` in the cycle after the BOOT_MS-th tick that is seen while the button stays held.
- R3: A press while `chipOff` is low arms no power-on request, however long the button is held.
- R4: Every press produces a one-cycle `forceOffReq` in the cycle after the FORCE_MS-th tick seen while the button stays held.
- R5: Releasing the button cancels both pending requests. A tick that arrives in the same cycle as the release does not complete a delay.
- R6: Holding the button from the off state first gives a power-on request and then a forced-shutdown request, each one once. A new press is needed before either can fire again.
- R7: A rising edge on `lidOpen` while `chipOff` is high produces a one-cycle `powerOnReq` in the next cycle. A lid that stays open does not repeat the request, and a lid edge while the chipset is on is ignored.
- R8: A `suspendEnter` pulse while the button is held and the forced-off action is still pending produces `forceOffReq` in the next cycle. With the button released the pulse has no effect.
- R9: A tick in the same cycle as the press edge is not counted toward either delay.
- R10: Requests are single-cycle pulses. A lid edge and a completed boot delay in the same cycle merge into a single `powerOnReq` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msTick | input | 1 | One-cycle pulse each millisecond |
| btnLevel | input | 1 | Debounced power button, 1 = pressed |
| lidOpen | input | 1 | Lid level, 1 = open |
| chipOff | input | 1 | 1 while the chipset is in an off state |
| suspendEnter | input | 1 | One-cycle pulse when the system enters suspend |
| powerOnReq | output | 1 | One-cycle power-on request |
| forceOffReq | output | 1 | One-cycle forced-shutdown request |

## Verification
A behavioural reference model predicts both outputs on every clock while directed holds run with short delay parameters. The holds cover these cases: a press held through reset, a press that has a tick in its own cycle, a release that coincides with the final tick, a press with the chipset on, and a full hold from off. Between them they separate counting from the press edge, counting from the next cycle, and cancellation. Lid edges are driven in both chipset states and with the lid held open, suspend pulses are given with the button held and released, and a lid edge is made to coincide with the end of the boot delay. A long stretch of random levels and ticks then exercises interleavings that the directed cases miss.

// File: rtl/pbtn_pkg.sv
package pbtn_pkg;

  // Strobes from control to the hold datapath
  typedef struct packed {
    logic clear;    // zero the hold counter
    logic advance;  // count one tick
  } holdCmd_t;

  // Observations from the datapath back to control
  typedef struct packed {
    logic pressEdge;  // button went from released to pressed this cycle
    logic held;       // button pressed this cycle and the one before
    logic lidEdge;    // lid went from closed to open this cycle
    logic bootDue;    // next counted tick completes the boot delay
    logic forceDue;   // next counted tick completes the forced-off delay
  } holdSense_t;

endpackage

// File: rtl/pbtn_hold_datapath.sv
module pbtn_hold_datapath
  import pbtn_pkg::*;
#(
  parameter int BOOT_MS  = 10,
  parameter int FORCE_MS = 8000,
  parameter bit LID_WAKE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       btnLevel,
  input  logic       lidOpen,
  input  holdCmd_t   cmd,
  output holdSense_t sense
);

  localparam int CNT_W = $clog2(FORCE_MS + 1);
  localparam logic [CNT_W-1:0] BOOT_LAST  = CNT_W'(BOOT_MS - 1);
  localparam logic [CNT_W-1:0] FORCE_LAST = CNT_W'(FORCE_MS - 1);
  localparam logic [CNT_W-1:0] CNT_TOP    = CNT_W'(FORCE_MS);

  logic             btnPrev;
  logic [CNT_W-1:0] holdCnt;
  logic             lidRise;

  // Resetting to "pressed" means a button held through reset is no press
  always_ff @(posedge clk) begin
    if (!rst_n) btnPrev <= 1'b1;
    else        btnPrev <= btnLevel;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                               holdCnt <= '0;
    else if (cmd.clear)                       holdCnt <= '0;
    else if (cmd.advance && holdCnt != CNT_TOP) holdCnt <= holdCnt + 1'b1;
  end

  generate
    if (LID_WAKE) begin : g_lid
      logic lidPrev;
      always_ff @(posedge clk) begin
        if (!rst_n) lidPrev <= 1'b1;
        else        lidPrev <= lidOpen;
      end
      assign lidRise = lidOpen & ~lidPrev;
    end else begin : g_nolid
      assign lidRise = 1'b0;
    end
  endgenerate

  always_comb begin
    sense.pressEdge = btnLevel & ~btnPrev;
    sense.held      = btnLevel & btnPrev;
    sense.lidEdge   = lidRise;
    sense.bootDue   = (holdCnt == BOOT_LAST);
    sense.forceDue  = (holdCnt == FORCE_LAST);
  end

  // A released button leaves the counter at zero
  assert_cnt_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !btnLevel |=> (holdCnt == '0));

  // The counter never passes the forced-off limit
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    holdCnt <= CNT_TOP);

  // A press edge restarts counting, so a tick in that cycle is lost
  assert_press_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (btnLevel && !btnPrev) |=> (holdCnt == '0));

endmodule

// File: rtl/pbtn_hold_control.sv
module pbtn_hold_control
  import pbtn_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       msTick,
  input  logic       btnLevel,
  input  logic       chipOff,
  input  logic       suspendEnter,
  input  holdSense_t sense,
  output holdCmd_t   cmd,
  output logic       powerOnReq,
  output logic       forceOffReq
);

  logic bootArmed;
  logic forceArmed;
  logic bootFire;
  logic forceFire;
  logic lidWake;

  always_comb begin
    cmd.clear   = ~btnLevel | sense.pressEdge;
    cmd.advance = sense.held & msTick;
  end

  assign bootFire  = bootArmed & cmd.advance & sense.bootDue;
  assign forceFire = forceArmed & sense.held &
                     ((cmd.advance & sense.forceDue) | suspendEnter);
  assign lidWake   = sense.lidEdge & chipOff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bootArmed  <= 1'b0;
      forceArmed <= 1'b0;
    end else if (!btnLevel) begin
      bootArmed  <= 1'b0;
      forceArmed <= 1'b0;
    end else if (sense.pressEdge) begin
      bootArmed  <= chipOff;
      forceArmed <= 1'b1;
    end else begin
      if (bootFire)  bootArmed  <= 1'b0;
      if (forceFire) forceArmed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      powerOnReq  <= 1'b0;
      forceOffReq <= 1'b0;
    end else begin
      powerOnReq  <= bootFire | lidWake;
      forceOffReq <= forceFire;
    end
  end

  assert_suspend_force_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (forceArmed && btnLevel && suspendEnter) |=> forceOffReq);

  assert_lid_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sense.lidEdge && chipOff) |=> powerOnReq);

  assert_release_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !btnLevel |=> !forceOffReq);

  assert_force_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    forceOffReq |-> !forceArmed);

  assert_chip_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sense.pressEdge && !chipOff) |=> !bootArmed);

  assert_force_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    forceOffReq |=> !forceOffReq);

endmodule

// File: rtl/pbtn_hold_timer.sv
module pbtn_hold_timer #(
  parameter int BOOT_MS  = 10,
  parameter int FORCE_MS = 8000,
  parameter bit LID_WAKE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic msTick,
  input  logic btnLevel,
  input  logic lidOpen,
  input  logic chipOff,
  input  logic suspendEnter,
  output logic powerOnReq,
  output logic forceOffReq
);

  pbtn_pkg::holdCmd_t   cmd;
  pbtn_pkg::holdSense_t sense;

  pbtn_hold_datapath #(
    .BOOT_MS (BOOT_MS),
    .FORCE_MS(FORCE_MS),
    .LID_WAKE(LID_WAKE)
  ) u_datapath (
    .clk     (clk),
    .rst_n   (rst_n),
    .btnLevel(btnLevel),
    .lidOpen (lidOpen),
    .cmd     (cmd),
    .sense   (sense)
  );

  pbtn_hold_control u_control (
    .clk         (clk),
    .rst_n       (rst_n),
    .msTick      (msTick),
    .btnLevel    (btnLevel),
    .chipOff     (chipOff),
    .suspendEnter(suspendEnter),
    .sense       (sense),
    .cmd         (cmd),
    .powerOnReq  (powerOnReq),
    .forceOffReq (forceOffReq)
  );

endmodule

// File: tb/pbtn_hold_timer_bench.sv
module pbtn_hold_timer_bench;

  localparam int BOOT  = 3;
  localparam int FORCE = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic msTick = 1'b0;
  logic btnLevel = 1'b0;
  logic lidOpen = 1'b0;
  logic chipOff = 1'b1;
  logic suspendEnter = 1'b0;
  logic powerOnReq;
  logic forceOffReq;

  always #5 clk = ~clk;

  pbtn_hold_timer #(.BOOT_MS(BOOT), .FORCE_MS(FORCE), .LID_WAKE(1'b1)) u_pbtn_hold_timer (
    .clk(clk), .rst_n(rst_n), .msTick(msTick), .btnLevel(btnLevel),
    .lidOpen(lidOpen), .chipOff(chipOff), .suspendEnter(suspendEnter),
    .powerOnReq(powerOnReq), .forceOffReq(forceOffReq)
  );

  int checks = 0;
  int fails = 0;
  int onSeen = 0;
  int offSeen = 0;
  string tag = "R1";
  bit done = 0;

  // Reference model state
  bit mPrevBtn, mPrevLid, mBoot, mForce, expOn, expOff;
  int mCnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      mPrevBtn = 1; mPrevLid = 1; mBoot = 0; mForce = 0; mCnt = 0;
      expOn = 0; expOff = 0;
    end else begin
      expOn = 0; expOff = 0;
      if (!btnLevel) begin
        mBoot = 0; mForce = 0; mCnt = 0;
      end else if (!mPrevBtn) begin
        mBoot = chipOff; mForce = 1; mCnt = 0;
      end else begin
        if (msTick) mCnt++;
        if (mBoot && msTick && mCnt == BOOT) begin expOn = 1; mBoot = 0; end
        if (mForce && ((msTick && mCnt == FORCE) || suspendEnter)) begin
          expOff = 1; mForce = 0;
        end
      end
      if (lidOpen && !mPrevLid && chipOff) expOn = 1;
      mPrevBtn = btnLevel;
      mPrevLid = lidOpen;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(powerOnReq == expOn, {tag, " powerOnReq"}, powerOnReq, expOn);
      check(forceOffReq == expOff, {tag, " forceOffReq"}, forceOffReq, expOff);
      onSeen += int'(powerOnReq);
      offSeen += int'(forceOffReq);
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      msTick = 1; step();
      msTick = 0; step();
    end
  endtask

  task automatic clearSeen();
    step(2);
    onSeen = 0;
    offSeen = 0;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: button held through reset
    btnLevel = 1;
    step(3);
    check(powerOnReq == 0 && forceOffReq == 0, "R1 reset outputs", powerOnReq, 0);
    rst_n = 1;
    step();
    tag = "R1";
    ticks(FORCE + 3);
    check(onSeen == 0 && offSeen == 0, "R1 no press through reset", onSeen + offSeen, 0);
    btnLevel = 0;
    clearSeen();

    // R9 and R2: tick in press cycle ignored, boot after BOOT ticks
    tag = "R2";
    chipOff = 1; btnLevel = 1; msTick = 1; step(); msTick = 0; step();
    ticks(BOOT - 1);
    step();
    check(onSeen == 0, "R9 tick on press edge not counted", onSeen, 0);
    ticks(1);
    step();
    check(onSeen == 1, "R2 boot request after delay", onSeen, 1);
    btnLevel = 0;
    step(2);
    check(offSeen == 0, "R5 release cancels forced-off", offSeen, 0);
    clearSeen();

    // R3: chipset on, no boot
    tag = "R3";
    chipOff = 0; btnLevel = 1; step();
    ticks(BOOT + 2);
    check(onSeen == 0, "R3 no boot while chipset on", onSeen, 0);
    btnLevel = 0;
    clearSeen();

    // R4 and R6: full hold from off
    tag = "R6";
    chipOff = 1; btnLevel = 1; step();
    ticks(FORCE + 4);
    check(onSeen == 1, "R6 boot once during hold", onSeen, 1);
    check(offSeen == 1, "R4 forced-off once after long hold", offSeen, 1);
    btnLevel = 0;
    clearSeen();

    // R5: release together with the final tick
    tag = "R5";
    chipOff = 1; btnLevel = 1; step();
    ticks(BOOT - 1);
    msTick = 1; btnLevel = 0; step();
    msTick = 0; step(3);
    check(onSeen == 0, "R5 release on final tick cancels boot", onSeen, 0);
    clearSeen();

    // R7: lid edges
    tag = "R7";
    chipOff = 1; lidOpen = 1; step(6);
    check(onSeen == 1, "R7 lid open while off wakes once", onSeen, 1);
    lidOpen = 0; step(); chipOff = 0; step();
    lidOpen = 1; step(3);
    check(onSeen == 1, "R7 lid edge while on ignored", onSeen, 1);
    lidOpen = 0; chipOff = 1;
    clearSeen();

    // R8: suspend while held
    tag = "R8";
    chipOff = 0; btnLevel = 1; step();
    ticks(2);
    suspendEnter = 1; step(); suspendEnter = 0; step();
    check(offSeen == 1, "R8 suspend while held forces off", offSeen, 1);
    ticks(FORCE);
    check(offSeen == 1, "R6 forced-off not repeated", offSeen, 1);
    btnLevel = 0; step();
    suspendEnter = 1; step(); suspendEnter = 0; step(2);
    check(offSeen == 1, "R8 suspend with button released ignored", offSeen, 1);
    clearSeen();

    // R10: lid edge coinciding with boot completion
    tag = "R10";
    chipOff = 1; btnLevel = 1; step();
    ticks(BOOT - 1);
    msTick = 1; lidOpen = 1; step();
    msTick = 0; step(3);
    check(onSeen == 1, "R10 merged single pulse", onSeen, 1);
    btnLevel = 0; lidOpen = 0;
    clearSeen();

    // Random interleavings, compared every cycle against the model
    tag = "R10 random";
    for (int i = 0; i < 4000; i++) begin
      msTick = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 29) == 0) btnLevel = ~btnLevel;
      if ($urandom_range(0, 49) == 0) lidOpen = ~lidOpen;
      if ($urandom_range(0, 79) == 0) chipOff = ~chipOff;
      suspendEnter = ($urandom_range(0, 39) == 0);
      step();
    end
    msTick = 0; suspendEnter = 0;
    step(2);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule